// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block is the front end of a single general-purpose DMA channel. It decides when a transfer may start and then steps it through its two bus phases. The trigger comes from one of five selectable request lines: two external pins, a timer tick, a UART request or a USB request. A timer request is only a trigger, since this block carries no data path at all. A channel can also run unsynchronized, pacing itself with no request line once software starts it.

Each transfer is one read (fetch) cycle followed directly by one write (deposit) cycle. There are three synchronization modes:

- **Source-synchronized:** the request is sampled again in the cycle after the deposit.
- **Destination-synchronized:** the request is blanked for a fixed window after the write strobe ends. During that window the channel drops its bus-busy flag, so the target has time to withdraw its request and other masters can use the bus.
- **Unsynchronized:** transfers follow one another with no request.

A transfer count, loaded with the configuration, stops the channel and raises a done flag after the last deposit.

Software loads source, mode and count while the channel is stopped, then pulses the start input. The block has no streaming data interface, so every pin is a plain level or one-cycle pulse and no back-pressure rules apply.

Top module: `dma_req_seq`

## Requirements
- R1: `cfg_src` picks the request line: 0 = ext_req[0], 1 = ext_req[1], 2 = tmr_req, 3 = uart_req, 4 = usb_req; lines not selected never start a transfer.
- R2: External pins pass two synchronizing flops. With the request raised just after an edge, rd_stb is first seen 3 cycles later for an external pin and 1 cycle later for an internal source.
- R3: A transfer is exactly one cycle of rd_stb, then one cycle of wr_stb in the next cycle; the two never overlap, and bus_busy is high for exactly those two cycles.
- R4: Mode encoding on `cfg_mode`: 00 = source-synchronized, 01 = destination-synchronized, 1x = unsynchronized.
- R5: In unsynchronized mode, transfers start after `chan_start` with no request, and each rd_stb follows the previous wr_stb by 2 cycles.
- R6: In source-synchronized mode, the request is sampled in the cycle after wr_stb. A live request gives the next rd_stb 2 cycles after wr_stb; a request dropped by then gives no further transfer.
- R7: In destination-synchronized mode, the request is ignored for 4 cycles after wr_stb falls and bus_busy is low during them. A request still present then gives rd_stb 6 cycles after wr_stb; a pulse inside the window is ignored.
- R8: Configuration writes (`cfg_we`) while the channel runs are ignored.
- R9: The count decrements once per deposit. After the last one the channel stops even with a live request, and `done` rises one cycle after that wr_stb. `done` clears when the channel is started again.
- R10: `chan_start` with a loaded count of zero does not start the channel.
- R11: After reset, rd_stb, wr_stb, bus_busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load source, mode and count (stopped channel only) |
| cfg_src | input | 3 | Request source select |
| cfg_mode | input | 2 | Synchronization mode |
| cfg_count | input | CNT_W | Number of transfers |
| chan_start | input | 1 | One-cycle pulse enabling the channel |
| ext_req | input | EXT_W | Asynchronous external request pins |
| tmr_req | input | 1 | Timer trigger |
| uart_req | input | 1 | UART request |
| usb_req | input | 1 | USB request |
| rd_stb | output | 1 | Fetch cycle strobe |
| wr_stb | output | 1 | Deposit cycle strobe |
| bus_busy | output | 1 | Channel holds the bus |
| done | output | 1 | Terminal count reached |

## Verification
Two events can land in the same cycle: the final deposit that exhausts the count, and a request that is still live at that moment. The bench holds the selected request high for the whole run. It then checks that the number of transfers equals the count exactly, that done rises right after the last write strobe, and that no extra fetch follows.

A second kind of collision is a request that toggles inside the destination blanking window. It is provoked by pulsing the request during the window and dropping it before the window ends. The check is that no fetch follows.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_DEPOSIT = 2'd2,
    ST_BLANK   = 2'd3
  } xfer_st_t;

  localparam logic [1:0] MODE_SRC = 2'b00;
  localparam logic [1:0] MODE_DST = 2'b01;
  localparam int         NUM_SRC  = 5;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select #(
  parameter int N  = 5,
  parameter int SW = 3
) (
  input  logic [N-1:0]  reqs,
  input  logic [SW-1:0] sel,
  output logic          req_o
);
  always_comb begin
    req_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == i[SW-1:0]) req_o = reqs[i];
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             req,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             busy,
  output logic             done,
  output logic             running
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  xfer_st_t         st;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    blank;
  logic             en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      blank <= '0;
      en    <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (cfg_load) cnt <= cfg_count;
      if (start && !en && cnt != '0) begin
        en   <= 1'b1;
        done <= 1'b0;
      end
      unique case (st)
        ST_IDLE: if (en && (mode[1] || req)) st <= ST_FETCH;
        ST_FETCH: st <= ST_DEPOSIT;
        ST_DEPOSIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            en   <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (mode == MODE_DST) begin
            st    <= ST_BLANK;
            blank <= BW'(BLANK_CYC - 1);
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_BLANK: begin
          if (blank == '0) st <= ST_IDLE;
          else             blank <= blank - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_stb  = (st == ST_FETCH);
  assign wr_stb  = (st == ST_DEPOSIT);
  assign busy    = rd_stb | wr_stb;
  assign running = en;
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BLANK_CYC   = 4,
  parameter int EXT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_src,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             chan_start,
  input  logic [EXT_W-1:0] ext_req,
  input  logic             tmr_req,
  input  logic             uart_req,
  input  logic             usb_req,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             bus_busy,
  output logic             done
);
  localparam int NSRC = EXT_W + 3;

  logic [EXT_W-1:0] ext_s;
  logic [NSRC-1:0]  src_vec;
  logic [2:0]       src_q;
  logic [1:0]       mode_q;
  logic             req_sel;
  logic             running;
  logic             cfg_ok;

  dma_req_sync #(.W(EXT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_req), .d_sync(ext_s)
  );

  assign src_vec = {usb_req, uart_req, tmr_req, ext_s};

  dma_req_select #(.N(NSRC), .SW(3)) u_sel (
    .reqs(src_vec), .sel(src_q), .req_o(req_sel)
  );

  assign cfg_ok = cfg_we && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mode_q <= MODE_SRC;
    end else if (cfg_ok) begin
      src_q  <= cfg_src;
      mode_q <= cfg_mode;
    end
  end

  dma_xfer_seq #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_ok), .cfg_count(cfg_count),
    .start(chan_start), .mode(mode_q), .req(req_sel),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .busy(bus_busy),
    .done(done), .running(running)
  );
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk #(
  parameter int BLANK_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       bus_busy,
  input logic       done,
  input logic       cfg_we,
  input logic       running,
  input logic [1:0] mode_q,
  input logic [2:0] src_q
);
  localparam int GW = $clog2(BLANK_CYC + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] since_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_wr <= GMAX;
    else if (wr_stb)           since_wr <= '0;
    else if (since_wr != GMAX) since_wr <= since_wr + 1'b1;
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> wr_stb);
  // R3
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb && bus_busy == 1'b0);
  // R7
  dst_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && rd_stb) |-> since_wr >= GW'(BLANK_CYC + 1));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && running) |=> ($stable(mode_q) && $stable(src_q)));
  // R9
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_stb));
  // R9
  done_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);
endmodule

bind dma_req_seq dma_req_seq_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .bus_busy(bus_busy), .done(done), .cfg_we(cfg_we), .running(running),
  .mode_q(mode_q), .src_q(src_q)
);

// File: tb/sim_dma_req_seq.sv
`timescale 1ns/1ps
module sim_dma_req_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_src = '0;
  logic [1:0] cfg_mode = '0;
  logic [7:0] cfg_count = '0;
  logic       chan_start = 1'b0;
  logic [1:0] ext_req = '0;
  logic       tmr_req = 1'b0, uart_req = 1'b0, usb_req = 1'b0;
  logic       rd_stb, wr_stb, bus_busy, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dma_req_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .chan_start(chan_start),
    .ext_req(ext_req), .tmr_req(tmr_req), .uart_req(uart_req),
    .usb_req(usb_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bus_busy(bus_busy), .done(done)
  );

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] mode;
    logic [7:0] cnt;
    logic       hold;
    logic [7:0] xfers;
    logic [7:0] gap;
    logic       fin;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 2'd0, 8'd3, 1'b1, 8'd3, 8'd2, 1'b1},
    '{3'd1, 2'd1, 8'd2, 1'b1, 8'd2, 8'd6, 1'b1},
    '{3'd2, 2'd0, 8'd4, 1'b1, 8'd4, 8'd2, 1'b1},
    '{3'd3, 2'd1, 8'd3, 1'b1, 8'd3, 8'd6, 1'b1},
    '{3'd4, 2'd0, 8'd2, 1'b1, 8'd2, 8'd2, 1'b1},
    '{3'd2, 2'd0, 8'd3, 1'b0, 8'd0, 8'd0, 1'b0},
    '{3'd4, 2'd1, 8'd2, 1'b0, 8'd0, 8'd0, 1'b0},
    '{3'd0, 2'd2, 8'd3, 1'b0, 8'd3, 8'd2, 1'b1},
    '{3'd1, 2'd3, 8'd1, 1'b0, 8'd1, 8'd0, 1'b1},
    '{3'd3, 2'd0, 8'd1, 1'b0, 8'd0, 8'd0, 1'b0}
  };

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; chan_start = 1'b0;
    ext_req = '0; tmr_req = 1'b0; uart_req = 1'b0; usb_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_cfg(input int src, input int mode, input int cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_src = 3'(src); cfg_mode = 2'(mode); cfg_count = 8'(cnt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    chan_start = 1'b1;
    @(negedge clk);
    chan_start = 1'b0;
  endtask

  task automatic set_reqs(input int sel, input logic lvl, input logic oth);
    ext_req = {oth, oth}; tmr_req = oth; uart_req = oth; usb_req = oth;
    case (sel)
      0: ext_req[0] = lvl;
      1: ext_req[1] = lvl;
      2: tmr_req = lvl;
      3: uart_req = lvl;
      default: usb_req = lvl;
    endcase
  endtask

  task automatic run_win(input int n, output int nrd, output int nwr,
                         output int nbusy, output int gap);
    int last_wr;
    nrd = 0; nwr = 0; nbusy = 0; gap = 0; last_wr = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rd_stb) begin
        nrd++;
        if (last_wr >= 0 && gap == 0) gap = k - last_wr;
      end
      if (wr_stb) begin nwr++; last_wr = k; end
      if (bus_busy) nbusy++;
    end
  endtask

  initial begin
    #1400000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nrd, nwr, nb, gp, k;

    // R11: reset state
    do_reset();
    chk(!rd_stb && !wr_stb && !bus_busy && !done, "R11 reset outputs",
        {rd_stb, wr_stb, bus_busy, done}, 0);

    // Table walk: R1 R4 R5 R6 R7 R9
    foreach (VEC[i]) begin
      do_reset();
      do_cfg(VEC[i].src, VEC[i].mode, VEC[i].cnt);
      set_reqs(VEC[i].src, VEC[i].hold, 1'b1);
      if (VEC[i].mode[1]) set_reqs(VEC[i].src, 1'b0, 1'b0);
      do_start();
      run_win(80, nrd, nwr, nb, gp);
      chk(nrd == VEC[i].xfers && nwr == VEC[i].xfers,
          $sformatf("R1/R9 vec%0d xfer count", i), nrd, VEC[i].xfers);
      chk(nb == 2 * VEC[i].xfers, $sformatf("R3 vec%0d busy cycles", i), nb, 2 * VEC[i].xfers);
      chk(done == VEC[i].fin, $sformatf("R9 vec%0d done", i), done, VEC[i].fin);
      if (VEC[i].xfers > 1)
        chk(gp == VEC[i].gap, $sformatf("R6/R7/R5 vec%0d wr-to-rd gap", i), gp, VEC[i].gap);
    end

    // R2: internal source latency
    do_reset();
    do_cfg(2, 0, 1);
    do_start();
    tmr_req = 1'b1;
    k = 0;
    for (int j = 0; j < 10 && k == 0; j++) begin
      @(negedge clk);
      if (rd_stb) k = j + 1;
    end
    chk(k == 1, "R2 timer latency", k, 1);

    // R2: external pin latency through synchronizer
    do_reset();
    do_cfg(0, 0, 1);
    do_start();
    ext_req[0] = 1'b1;
    k = 0;
    for (int j = 0; j < 10 && k == 0; j++) begin
      @(negedge clk);
      if (rd_stb) k = j + 1;
    end
    chk(k == 3, "R2 external latency", k, 3);

    // R8: config write while running ignored
    do_reset();
    do_cfg(2, 0, 2);
    do_start();
    do_cfg(4, 2, 5);
    usb_req = 1'b1;
    run_win(10, nrd, nwr, nb, gp);
    chk(nrd == 0, "R8 new mode/source ignored", nrd, 0);
    tmr_req = 1'b1;
    run_win(30, nrd, nwr, nb, gp);
    chk(nrd == 2 && done, "R8 original count kept", nrd, 2);

    // R10: start with zero count
    do_reset();
    do_cfg(2, 2, 0);
    do_start();
    run_win(10, nrd, nwr, nb, gp);
    chk(nrd == 0 && !done, "R10 zero count start", nrd, 0);

    // R7: request pulse inside blanking window ignored
    do_reset();
    do_cfg(2, 1, 3);
    tmr_req = 1'b1;
    do_start();
    for (int j = 0; j < 10 && !wr_stb; j++) @(negedge clk);
    tmr_req = 1'b0;
    @(negedge clk); tmr_req = 1'b1;
    @(negedge clk); tmr_req = 1'b0;
    run_win(20, nrd, nwr, nb, gp);
    chk(nrd == 0, "R7 pulse in window ignored", nrd, 0);

    // R6: request withdrawn by the deposit cycle
    do_reset();
    do_cfg(3, 0, 3);
    uart_req = 1'b1;
    do_start();
    for (int j = 0; j < 10 && !wr_stb; j++) @(negedge clk);
    uart_req = 1'b0;
    run_win(20, nrd, nwr, nb, gp);
    chk(nrd == 0 && !done, "R6 dropped request stops", nrd, 0);

    // R9: done clears on restart and sets again
    do_reset();
    do_cfg(2, 0, 1);
    tmr_req = 1'b1;
    do_start();
    run_win(10, nrd, nwr, nb, gp);
    chk(done, "R9 done after single", done, 1);
    do_cfg(2, 0, 1);
    @(negedge clk); chan_start = 1'b1;
    @(negedge clk); chan_start = 1'b0;
    chk(!done, "R9 done cleared on start", done, 0);
    run_win(10, nrd, nwr, nb, gp);
    chk(done && nrd == 1, "R9 second run", nrd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule